// File: doc/BRIEF.md
# Host Bus Address Command Decoder

This block sits in a system controller. For every request on the host bus it picks one destination. A request carries a 36-bit address, a separate most-significant address flag and a 4-bit command code. The possible destinations are main DRAM, the controller's internal remap-control register window, the graphics-port bridge and the PCI bus. DRAM-bound requests that land inside the graphics aperture are also marked for translation through the aperture remap table before they reach DRAM.

The decision depends on two things: which class the command belongs to, and the state of the MSB flag. Block (cache-line) commands reach DRAM with the flag clear. Masked writes reach DRAM with the flag set. Masked commands with the flag clear and a zero upper nibble are treated as memory-mapped I/O. That traffic is resolved by fixed priority, in this order: register window, legacy VGA range, the two bridge windows, and finally PCI. Anything else is reported as having no target. The result is registered, so it appears one clock after the request.

Top module: `host_route_decoder`

## Requirements
- R1: A block command (in_cmd[3:2] = 2'b00) with in_msb = 0 selects DRAM (out_tgt = 4'b0001), whatever in_addr[35:32] holds.
- R2: A masked write (in_cmd[3:2] = 2'b01; byte, longword or quadword) with in_msb = 1 selects DRAM (out_tgt = 4'b0001).
- R3: out_xlate is 1 exactly when the request selects DRAM and cfg_ap_base <= in_addr[31:0] < cfg_ap_base + cfg_ap_len. The sum is taken without wrap. out_xlate stays 0 for every non-DRAM result and whenever cfg_ap_len = 0.
- R4: A masked command (in_cmd[3:2] = 2'b01 or 2'b10) with in_msb = 0 is memory-mapped I/O only when in_addr[35:32] = 0. With a nonzero upper nibble it has no target.
- R5: Memory-mapped I/O whose in_addr[31:12] equals cfg_reg_base[31:12] selects the register window (out_tgt = 4'b0010). This rule takes priority over the VGA and bridge rules.
- R6: When cfg_vga_en = 1, memory-mapped I/O in 0xA0000..0xBFFFF selects the bridge (out_tgt = 4'b0100). When cfg_vga_en = 0, that range falls through to the later rules.
- R7: Memory-mapped I/O selects the bridge when in_addr[31:20] lies within either [cfg_mem_base, cfg_mem_limit] or [cfg_pf_base, cfg_pf_limit]. Both bounds are inclusive and counted in 1 MB units.
- R8: Memory-mapped I/O that matches none of R5 to R7 selects PCI (out_tgt = 4'b1000).
- R9: Any other combination sets out_none = 1, with out_tgt = 0 and out_xlate = 0. This covers a block command with in_msb = 1, a masked read with in_msb = 1, and in_cmd[3:2] = 2'b11.
- R10: out_valid equals in_valid from one clock earlier. While out_valid = 0, out_tgt, out_xlate and out_none are all 0. After reset all outputs are 0.
- R11: While out_valid = 1, exactly one of the four out_tgt bits or out_none is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| in_addr | input | 36 | Request address |
| in_msb | input | 1 | Most-significant address flag |
| in_cmd | input | 4 | Command code; [3:2] is the class |
| cfg_ap_base | input | 32 | Graphics aperture base |
| cfg_ap_len | input | 32 | Graphics aperture length in bytes |
| cfg_reg_base | input | 32 | Register window base (4 KB window) |
| cfg_mem_base | input | 12 | Bridge memory window base, 1 MB units |
| cfg_mem_limit | input | 12 | Bridge memory window limit, inclusive |
| cfg_pf_base | input | 12 | Bridge prefetchable window base, 1 MB units |
| cfg_pf_limit | input | 12 | Bridge prefetchable window limit, inclusive |
| cfg_vga_en | input | 1 | Send legacy VGA range to the bridge |
| out_valid | output | 1 | Decode result valid |
| out_tgt | output | 4 | One-hot target: [0] DRAM, [1] register window, [2] bridge, [3] PCI |
| out_xlate | output | 1 | DRAM access needs aperture translation |
| out_none | output | 1 | Request matches no route |

## Verification
The same addresses are sent with each command class and with both flag values. This separates the block-versus-masked-write flag inversion from the routing that depends on address alone. Addresses sit on both sides of every boundary: the first and last byte of the aperture, of the register window, of the VGA range and of each 1 MB bridge window. These show off-by-one and inclusive/exclusive mistakes. The register window is then moved inside a bridge window and the VGA enable is cleared, which exposes any error in priority order. The aperture address is also sent as memory-mapped I/O, and again with a nonzero upper nibble. This shows that translation uses only bits [31:0] and applies only to DRAM traffic.

// File: rtl/hbd_pkg.sv
package hbd_pkg;
  typedef enum logic [1:0] {
    CC_BLOCK = 2'b00,
    CC_MWR   = 2'b01,
    CC_MRD   = 2'b10,
    CC_OTHER = 2'b11
  } cmd_class_e;

  localparam int TGT_N  = 4;
  localparam int TI_DRAM = 0;
  localparam int TI_REG  = 1;
  localparam int TI_BRG  = 2;
  localparam int TI_PCI  = 3;
endpackage

// File: rtl/hbd_classify.sv
module hbd_classify
  import hbd_pkg::*;
#(
  parameter int ADDR_W = 36,
  parameter int LOW_W  = 32,
  parameter int CMD_W  = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              msb,
  input  logic [CMD_W-1:0]  cmd,
  input  logic [LOW_W-1:0]  ap_base,
  input  logic [LOW_W-1:0]  ap_len,
  output logic              is_dram,
  output logic              is_mmio,
  output logic              xlate
);
  localparam int UP_W = ADDR_W - LOW_W;

  cmd_class_e       cls;
  logic [UP_W-1:0]  upper;
  logic [LOW_W:0]   lo_ext;
  logic [LOW_W:0]   ap_end;
  logic             in_ap;

  always_comb begin
    cls     = cmd_class_e'(cmd[CMD_W-1 -: 2]);
    upper   = addr[ADDR_W-1:LOW_W];
    lo_ext  = {1'b0, addr[LOW_W-1:0]};
    ap_end  = {1'b0, ap_base} + {1'b0, ap_len};
    in_ap   = (lo_ext >= {1'b0, ap_base}) && (lo_ext < ap_end);
    is_dram = ((cls == CC_BLOCK) && !msb) || ((cls == CC_MWR) && msb);
    is_mmio = ((cls == CC_MWR) || (cls == CC_MRD)) && !msb && (upper == '0);
    xlate   = is_dram && in_ap;
  end
endmodule

// File: rtl/hbd_win_cmp.sv
module hbd_win_cmp #(
  parameter int LOW_W    = 32,
  parameter int GRAN_LSB = 20
) (
  input  logic [LOW_W-1:0]          addr_lo,
  input  logic [LOW_W-GRAN_LSB-1:0] base,
  input  logic [LOW_W-GRAN_LSB-1:0] limit,
  output logic                      hit
);
  logic [LOW_W-GRAN_LSB-1:0] key;

  always_comb begin
    key = addr_lo[LOW_W-1:GRAN_LSB];
    hit = (key >= base) && (key <= limit);
  end
endmodule

// File: rtl/hbd_mmio_route.sv
module hbd_mmio_route
  import hbd_pkg::*;
#(
  parameter int LOW_W    = 32,
  parameter int GRAN_LSB = 20,
  parameter int REG_LSB  = 12,
  parameter int NUM_WIN  = 2,
  localparam int WIN_W   = LOW_W - GRAN_LSB
) (
  input  logic [LOW_W-1:0] addr_lo,
  input  logic [LOW_W-1:0] reg_base,
  input  logic [WIN_W-1:0] win_base  [NUM_WIN],
  input  logic [WIN_W-1:0] win_limit [NUM_WIN],
  input  logic             vga_en,
  output logic [TGT_N-1:0] sel
);
  localparam logic [LOW_W-1:0] VGA_LO = LOW_W'('hA0000);
  localparam logic [LOW_W-1:0] VGA_HI = LOW_W'('hBFFFF);

  logic [NUM_WIN-1:0] win_hit;
  logic               reg_hit;
  logic               vga_hit;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    hbd_win_cmp #(.LOW_W(LOW_W), .GRAN_LSB(GRAN_LSB)) u_cmp (
      .addr_lo (addr_lo),
      .base    (win_base[w]),
      .limit   (win_limit[w]),
      .hit     (win_hit[w])
    );
  end

  always_comb begin
    reg_hit = (addr_lo[LOW_W-1:REG_LSB] == reg_base[LOW_W-1:REG_LSB]);
    vga_hit = vga_en && (addr_lo >= VGA_LO) && (addr_lo <= VGA_HI);
    sel     = '0;
    if (reg_hit)           sel[TI_REG] = 1'b1;
    else if (vga_hit)      sel[TI_BRG] = 1'b1;
    else if (|win_hit)     sel[TI_BRG] = 1'b1;
    else                   sel[TI_PCI] = 1'b1;
  end
endmodule

// File: rtl/host_route_decoder.sv
module host_route_decoder
  import hbd_pkg::*;
#(
  parameter int ADDR_W   = 36,
  parameter int LOW_W    = 32,
  parameter int CMD_W    = 4,
  parameter int GRAN_LSB = 20,
  parameter int REG_LSB  = 12,
  localparam int WIN_W   = LOW_W - GRAN_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_msb,
  input  logic [CMD_W-1:0]  in_cmd,
  input  logic [LOW_W-1:0]  cfg_ap_base,
  input  logic [LOW_W-1:0]  cfg_ap_len,
  input  logic [LOW_W-1:0]  cfg_reg_base,
  input  logic [WIN_W-1:0]  cfg_mem_base,
  input  logic [WIN_W-1:0]  cfg_mem_limit,
  input  logic [WIN_W-1:0]  cfg_pf_base,
  input  logic [WIN_W-1:0]  cfg_pf_limit,
  input  logic              cfg_vga_en,
  output logic              out_valid,
  output logic [TGT_N-1:0]  out_tgt,
  output logic              out_xlate,
  output logic              out_none
);
  localparam int NUM_WIN = 2;

  logic             c_dram, c_mmio, c_xlate;
  logic [TGT_N-1:0] mmio_sel;
  logic [WIN_W-1:0] wb [NUM_WIN];
  logic [WIN_W-1:0] wl [NUM_WIN];

  logic             valid_d, xlate_d, none_d;
  logic [TGT_N-1:0] tgt_d;

  assign wb[0] = cfg_mem_base;
  assign wl[0] = cfg_mem_limit;
  assign wb[1] = cfg_pf_base;
  assign wl[1] = cfg_pf_limit;

  hbd_classify #(.ADDR_W(ADDR_W), .LOW_W(LOW_W), .CMD_W(CMD_W)) u_cls (
    .addr    (in_addr),
    .msb     (in_msb),
    .cmd     (in_cmd),
    .ap_base (cfg_ap_base),
    .ap_len  (cfg_ap_len),
    .is_dram (c_dram),
    .is_mmio (c_mmio),
    .xlate   (c_xlate)
  );

  hbd_mmio_route #(.LOW_W(LOW_W), .GRAN_LSB(GRAN_LSB), .REG_LSB(REG_LSB),
                   .NUM_WIN(NUM_WIN)) u_mmio (
    .addr_lo   (in_addr[LOW_W-1:0]),
    .reg_base  (cfg_reg_base),
    .win_base  (wb),
    .win_limit (wl),
    .vga_en    (cfg_vga_en),
    .sel       (mmio_sel)
  );

  // next-state
  always_comb begin
    valid_d = in_valid;
    tgt_d   = '0;
    xlate_d = 1'b0;
    none_d  = 1'b0;
    if (in_valid) begin
      if (c_dram) begin
        tgt_d[TI_DRAM] = 1'b1;
        xlate_d        = c_xlate;
      end else if (c_mmio) begin
        tgt_d = mmio_sel;
      end else begin
        none_d = 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_tgt   <= '0;
      out_xlate <= 1'b0;
      out_none  <= 1'b0;
    end else begin
      out_valid <= valid_d;
      out_tgt   <= tgt_d;
      out_xlate <= xlate_d;
      out_none  <= none_d;
    end
  end

  // assertions
  p_cls_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(c_dram && c_mmio));

  p_xlate_dram_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_xlate |-> out_tgt[TI_DRAM]);

  p_one_result_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (($countones(out_tgt) + 32'(out_none)) == 1));

  p_valid_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_tgt == '0 && !out_xlate && !out_none));

  p_none_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_none |-> (out_tgt == '0 && !out_xlate));
endmodule

// File: tb/sim_host_route_decoder.sv
module sim_host_route_decoder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [35:0] in_addr;
  logic        in_msb;
  logic [3:0]  in_cmd;
  logic [31:0] cfg_ap_base, cfg_ap_len, cfg_reg_base;
  logic [11:0] cfg_mem_base, cfg_mem_limit, cfg_pf_base, cfg_pf_limit;
  logic        cfg_vga_en;
  logic        out_valid;
  logic [3:0]  out_tgt;
  logic        out_xlate, out_none;

  always #5 clk = ~clk;

  host_route_decoder u0 (.*);

  typedef struct {
    logic [3:0] tgt;
    logic       x;
    logic       none;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   n_run  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;

  localparam logic [3:0] DRAM = 4'b0001, REGW = 4'b0010, BRG = 4'b0100,
                         PCI  = 4'b1000, NONE = 4'b0000;
  localparam logic [3:0] BLK_RD = 4'h0, BLK_WR = 4'h1, MW_Q = 4'h4,
                         MW_B = 4'h6, MR_L = 4'h9, OTH = 4'hC;

  task automatic chk(input bit ok, input string tag, input string act, input string exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %s expected %s", tag, act, exp);
    end
  endtask

  task automatic send(input logic [35:0] a, input logic m, input logic [3:0] c,
                      input logic [3:0] et, input logic ex, input string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; in_addr = a; in_msb = m; in_cmd = c;
    e.tgt = et; e.x = ex; e.none = (et == NONE); e.tag = tag;
    q.push_back(e);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q.size() == 0) begin
        chk(1'b0, "R10 unexpected result", "valid", "idle");
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(out_tgt == e.tgt && out_xlate == e.x && out_none == e.none, e.tag,
            $sformatf("tgt=%b x=%b none=%b", out_tgt, out_xlate, out_none),
            $sformatf("tgt=%b x=%b none=%b", e.tgt, e.x, e.none));
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_addr = '0; in_msb = 1'b0; in_cmd = '0;
    cfg_ap_base = 32'h4000_0000; cfg_ap_len = 32'h1000_0000;
    cfg_reg_base = 32'hF000_0000;
    cfg_mem_base = 12'hE00; cfg_mem_limit = 12'hE1F;
    cfg_pf_base  = 12'hD00; cfg_pf_limit  = 12'hD00;
    cfg_vga_en = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 0 && out_tgt == 0 && out_none == 0 && out_xlate == 0,
        "R10 reset state", $sformatf("v=%b tgt=%b", out_valid, out_tgt), "v=0 tgt=0000");

    send(36'h0_1000_0000, 0, BLK_RD, DRAM, 0, "R1 block msb clear");
    send(36'h1_4000_0000, 0, BLK_WR, DRAM, 1, "R1 block ignores upper nibble");
    send(36'h0_4000_0000, 0, BLK_WR, DRAM, 1, "R3 aperture first byte");
    send(36'h0_4FFF_FFFF, 0, BLK_RD, DRAM, 1, "R3 aperture last byte");
    send(36'h0_5000_0000, 0, BLK_RD, DRAM, 0, "R3 past aperture end");
    send(36'h0_3FFF_FFFF, 0, BLK_RD, DRAM, 0, "R3 below aperture");
    send(36'h0_4800_0000, 1, MW_Q, DRAM, 1, "R2 masked write msb set in aperture");
    send(36'h3_0000_0100, 1, MW_B, DRAM, 0, "R2 masked write msb set");
    send(36'h0_4000_0000, 0, MR_L, PCI, 0, "R3 aperture not applied to MMIO");
    send(36'h0_F000_0FFC, 0, MR_L, REGW, 0, "R5 register window top");
    send(36'h0_F000_0000, 0, MW_Q, REGW, 0, "R5 register window base");
    send(36'h0_F000_1000, 0, MR_L, PCI, 0, "R8 past register window");
    send(36'h0_000A_0000, 0, MW_B, BRG, 0, "R6 VGA low end");
    send(36'h0_000B_FFFF, 0, MR_L, BRG, 0, "R6 VGA high end");
    send(36'h0_000C_0000, 0, MR_L, PCI, 0, "R8 above VGA");
    send(36'h0_0009_FFFF, 0, MR_L, PCI, 0, "R8 below VGA");
    send(36'h0_E000_0000, 0, MR_L, BRG, 0, "R7 mem window base");
    send(36'h0_E1FF_FFFF, 0, MW_Q, BRG, 0, "R7 mem window limit inclusive");
    send(36'h0_E200_0000, 0, MR_L, PCI, 0, "R7 past mem window");
    send(36'h0_D00F_FFFF, 0, MR_L, BRG, 0, "R7 prefetch window");
    send(36'h0_D010_0000, 0, MR_L, PCI, 0, "R7 past prefetch window");
    send(36'h1_E000_0000, 0, MR_L, NONE, 0, "R4 masked read upper nonzero");
    send(36'h8_0000_1000, 0, MW_Q, NONE, 0, "R4 masked write msb clear upper nonzero");
    send(36'h0_1000_0000, 1, BLK_RD, NONE, 0, "R9 block msb set");
    send(36'h0_4000_0000, 1, MR_L, NONE, 0, "R9 masked read msb set");
    send(36'h0_1000_0000, 0, OTH, NONE, 0, "R9 other class");

    cfg_reg_base = 32'hE010_0000;
    send(36'h0_E010_0800, 0, MR_L, REGW, 0, "R5 register window beats bridge");
    send(36'h0_E020_0000, 0, MR_L, BRG, 0, "R7 bridge next to moved window");
    cfg_reg_base = 32'h000A_0000;
    send(36'h0_000A_0010, 0, MR_L, REGW, 0, "R5 register window beats VGA");
    cfg_reg_base = 32'hF000_0000;
    cfg_vga_en = 1'b0;
    send(36'h0_000A_0000, 0, MR_L, PCI, 0, "R6 VGA disabled to PCI");
    cfg_mem_base = 12'h000; cfg_mem_limit = 12'h000;
    send(36'h0_000B_0000, 0, MR_L, BRG, 0, "R6 VGA disabled falls to bridge window");
    cfg_mem_base = 12'hE00; cfg_mem_limit = 12'hE1F;
    cfg_ap_len = 32'h0;
    send(36'h0_4000_0000, 0, BLK_RD, DRAM, 0, "R3 zero aperture length");

    repeat (3) @(negedge clk);
    chk(out_valid == 0 && out_tgt == 0 && out_none == 0 && out_xlate == 0,
        "R10 idle outputs", $sformatf("v=%b tgt=%b", out_valid, out_tgt), "v=0 tgt=0000");
    chk(q.size() == 0, "R10 all results returned", $sformatf("%0d", q.size()), "0");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule